// File: doc/BRIEF.md
# Addressing-Mode Effective Address Generator

This block turns the operand-specifier part of an instruction into the value that the execute stage needs. A 3-bit mode code, up to two register values read earlier, and a 16-bit constant field go in. What comes out is either a memory address for a load or store or a plain operand value. A flag says which of the two the result is. Modes that produce an address are absolute, register-indirect, indexed and base-plus-index. Modes that produce a data value are register and immediate.

The unit is used one request at a time. The issue logic raises `req` for one clock with the mode, registers and constant valid. The result appears on the output registers in the next cycle with `out_valid` high for that cycle only. A small two-state machine tracks this. In `ST_IDLE` no result is presented. In `ST_DONE` a fresh result is on the outputs. The transition `TR_ISSUE` goes to `ST_DONE` whenever `req` is high, from either state. The transition `TR_DRAIN` returns to `ST_IDLE` when `req` is low. Between requests the result registers keep their last contents. Codes 110 and 111 are not modes and raise an illegal flag.

Top module: `ea_gen`

## Requirements
- R1: After reset `out_valid`, `out_is_addr` and `out_illegal` are 0 and `out_value` is 0.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `req` high, and 0 in the cycle after a cycle with `req` low.
- R3: Mode code 000 (register) gives `out_value` = `reg_a` and `out_is_addr` = 0.
- R4: Mode code 001 (immediate) gives `out_value` = `imm` sign-extended from bit 15 to 32 bits and `out_is_addr` = 0.
- R5: Mode code 010 (absolute) gives `out_value` = `imm` sign-extended from bit 15 and `out_is_addr` = 1, so only the lowest and highest 32 KiB of the address space are reachable.
- R6: Mode code 011 (register-indirect) gives `out_value` = `reg_a` and `out_is_addr` = 1.
- R7: Mode code 100 (indexed) gives `out_value` = `reg_a` + sign-extended `imm`, wrapping modulo 2^32, with `out_is_addr` = 1. A base of 1000 with a constant of 20 gives 1020, and a register holding 20 with a constant of 1000 also gives 1020.
- R8: Mode code 101 (base plus index) gives `out_value` = `reg_a` + `reg_b` + sign-extended `imm`, wrapping modulo 2^32, with `out_is_addr` = 1.
- R9: Mode codes 110 and 111 give `out_illegal` = 1, `out_value` = 0 and `out_is_addr` = 0. Every legal code gives `out_illegal` = 0.
- R10: In a cycle after `req` was low, `out_value`, `out_is_addr` and `out_illegal` keep the values they had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe; the inputs below are sampled when high |
| mode | input | 3 | Addressing-mode code |
| reg_a | input | 32 | First register value (base or operand) |
| reg_b | input | 32 | Second register value (index) |
| imm | input | 16 | Constant or offset field |
| out_valid | output | 1 | High for one cycle when a new result is presented |
| out_value | output | 32 | Effective address or operand value |
| out_is_addr | output | 1 | 1 when `out_value` is a memory address |
| out_illegal | output | 1 | 1 when the sampled mode code is undefined |

## Verification
The properties assume that `req` is a clean single-bit strobe and that `mode`, `reg_a`, `reg_b` and `imm` hold known values in every cycle where `req` is high. They also compare results with `$past` of those inputs, which is only meaningful if the inputs are steady across the sampling edge. The bench therefore changes inputs only on falling edges and always drives defined values, including during reset. It mixes directed wrap-around and sign-extension cases with random mode codes, both legal and illegal, and inserts idle cycles so the hold behaviour and the return to idle are both exercised.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    typedef enum logic [2:0] {
        AM_REG = 3'b000,
        AM_IMM = 3'b001,
        AM_ABS = 3'b010,
        AM_IND = 3'b011,
        AM_IDX = 3'b100,
        AM_BIX = 3'b101
    } am_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ea_state_e;

endpackage

// File: rtl/ea_sext.sv
module ea_sext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign dout = {{PAD_W{din[IN_W-1]}}, din};
        end else begin : g_nopad
            assign dout = din[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ea_operand_sel.sv
module ea_operand_sel
    import ea_gen_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        mode,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [DATA_W-1:0] imm_ext,
    output logic [DATA_W-1:0] term_a,
    output logic [DATA_W-1:0] term_b,
    output logic [DATA_W-1:0] term_c,
    output logic              is_addr,
    output logic              illegal
);
    always_comb begin
        term_a  = '0;
        term_b  = '0;
        term_c  = '0;
        is_addr = 1'b0;
        illegal = 1'b0;
        case (mode)
            AM_REG: begin
                term_a = reg_a;
            end
            AM_IMM: begin
                term_c = imm_ext;
            end
            AM_ABS: begin
                term_c  = imm_ext;
                is_addr = 1'b1;
            end
            AM_IND: begin
                term_a  = reg_a;
                is_addr = 1'b1;
            end
            AM_IDX: begin
                term_a  = reg_a;
                term_c  = imm_ext;
                is_addr = 1'b1;
            end
            AM_BIX: begin
                term_a  = reg_a;
                term_b  = reg_b;
                term_c  = imm_ext;
                is_addr = 1'b1;
            end
            default: begin
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ea_adder3.sv
module ea_adder3 #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] sum
);
    assign sum = a + b + c;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [2:0]        mode,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [OFS_W-1:0]  imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_value,
    output logic              out_is_addr,
    output logic              out_illegal
);
    ea_state_e         state_q, state_d;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] term_a, term_b, term_c, sum;
    logic              sel_is_addr, sel_illegal;

    ea_sext #(.IN_W(OFS_W), .OUT_W(DATA_W)) sext_i (
        .din  (imm),
        .dout (imm_ext)
    );

    ea_operand_sel #(.DATA_W(DATA_W)) sel_i (
        .mode    (mode),
        .reg_a   (reg_a),
        .reg_b   (reg_b),
        .imm_ext (imm_ext),
        .term_a  (term_a),
        .term_b  (term_b),
        .term_c  (term_c),
        .is_addr (sel_is_addr),
        .illegal (sel_illegal)
    );

    ea_adder3 #(.DATA_W(DATA_W)) add_i (
        .a   (term_a),
        .b   (term_b),
        .c   (term_c),
        .sum (sum)
    );

    // next-state: TR_ISSUE on req, TR_DRAIN otherwise
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = req ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_value   <= '0;
            out_is_addr <= 1'b0;
            out_illegal <= 1'b0;
        end else if (req) begin
            out_value   <= sum;
            out_is_addr <= sel_is_addr;
            out_illegal <= sel_illegal;
        end
    end

    assign out_valid = (state_q == ST_DONE);
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
    import ea_gen_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [2:0]        mode,
    input logic [DATA_W-1:0] reg_a,
    input logic [DATA_W-1:0] reg_b,
    input logic [OFS_W-1:0]  imm,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_value,
    input logic              out_is_addr,
    input logic              out_illegal
);
    // R2
    valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> out_valid);

    // R2
    idle_after_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !out_valid);

    // R3
    reg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == AM_REG |=> out_value == $past(reg_a) && !out_is_addr);

    // R6
    indirect_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == AM_IND |=> out_value == $past(reg_a) && out_is_addr);

    // R5
    absolute_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode == AM_ABS |=> out_is_addr
            && out_value[OFS_W-1:0] == $past(imm)
            && out_value[DATA_W-1:OFS_W] == {(DATA_W-OFS_W){out_value[OFS_W-1]}});

    // R9
    illegal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req && mode[2:1] == 2'b11 |=> out_illegal && !out_is_addr && out_value == '0);

    // R10
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(out_value) && $stable(out_is_addr) && $stable(out_illegal));
endmodule

bind ea_gen ea_gen_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) chk_i (.*);

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
    localparam int DW = 32;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [2:0]    mode = 3'b000;
    logic [DW-1:0] reg_a = '0;
    logic [DW-1:0] reg_b = '0;
    logic [OW-1:0] imm = '0;
    logic          out_valid;
    logic [DW-1:0] out_value;
    logic          out_is_addr;
    logic          out_illegal;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 0;

    logic          e_valid = 1'b0;
    logic [DW-1:0] e_value = '0;
    logic          e_addr = 1'b0;
    logic          e_ill = 1'b0;
    string         e_tag = "R1";

    always #10 clk = ~clk;

    ea_gen #(.DATA_W(DW), .OFS_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode),
        .reg_a(reg_a), .reg_b(reg_b), .imm(imm),
        .out_valid(out_valid), .out_value(out_value),
        .out_is_addr(out_is_addr), .out_illegal(out_illegal)
    );

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    // behavioural reference, updated after each rising edge
    task automatic model_edge();
        longint unsigned s;
        longint signed   x;
        x = longint'($signed(imm));
        if (!rst_n) begin
            e_valid = 0; e_value = '0; e_addr = 0; e_ill = 0; e_tag = "R1";
        end else if (req) begin
            e_valid = 1; e_ill = 0; e_tag = tag_of(mode);
            case (mode)
                3'd0: begin e_value = reg_a; e_addr = 0; end
                3'd1: begin e_value = DW'(x); e_addr = 0; end
                3'd2: begin e_value = DW'(x); e_addr = 1; end
                3'd3: begin e_value = reg_a; e_addr = 1; end
                3'd4: begin s = longint'(reg_a) + longint'(x); e_value = DW'(s); e_addr = 1; end
                3'd5: begin s = longint'(reg_a) + longint'(reg_b) + longint'(x); e_value = DW'(s); e_addr = 1; end
                default: begin e_value = '0; e_addr = 0; e_ill = 1; end
            endcase
        end else begin
            e_valid = 0;
            e_tag = "R10";
        end
    endtask

    task automatic compare();
        n_checks++;
        if (out_valid !== e_valid) begin
            n_bad++;
            $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, e_valid);
        end
        n_checks++;
        if (out_value !== e_value || out_is_addr !== e_addr || out_illegal !== e_ill) begin
            n_bad++;
            $display("FAIL %s value/addr/illegal actual=%h/%0b/%0b expected=%h/%0b/%0b",
                     e_tag, out_value, out_is_addr, out_illegal, e_value, e_addr, e_ill);
        end
    endtask

    task automatic cycle(input logic r, input logic [2:0] m,
                         input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic [OW-1:0] k);
        req = r; mode = m; reg_a = a; reg_b = b; imm = k;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    initial begin
        #100_000_000;
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
        rst_n = 1'b1;

        cycle(0, 3'd0, 32'h0, 32'h0, 16'h0);                    // R2 idle
        cycle(1, 3'd0, 32'hDEAD_BEEF, 32'h1111_1111, 16'h7777); // R3
        cycle(1, 3'd1, 32'h1234_5678, 32'h0, 16'h8001);         // R4 negative
        cycle(1, 3'd1, 32'h1234_5678, 32'h0, 16'h7FFF);         // R4 positive
        cycle(1, 3'd2, 32'hFFFF_FFFF, 32'h0, 16'hFFFC);         // R5 high region
        cycle(1, 3'd2, 32'h0, 32'h0, 16'h0100);                 // R5 low region
        cycle(1, 3'd3, 32'h8000_0040, 32'h5555_5555, 16'h1234); // R6
        cycle(1, 3'd4, 32'd1000, 32'h0, 16'd20);                // R7 base 1000 + 20
        cycle(1, 3'd4, 32'd20, 32'h0, 16'd1000);                // R7 20 + 1000
        cycle(1, 3'd4, 32'h0000_0010, 32'h0, 16'hFFF0);         // R7 negative offset
        cycle(1, 3'd4, 32'hFFFF_FFFF, 32'h0, 16'h0002);         // R7 wrap
        cycle(1, 3'd5, 32'd1000, 32'd12, 16'd8);                // R8
        cycle(1, 3'd5, 32'hFFFF_FFF0, 32'h0000_0020, 16'hFFFF); // R8 wrap
        cycle(0, 3'd6, 32'h1, 32'h2, 16'h3);                    // R10 hold
        cycle(0, 3'd1, 32'h9, 32'h9, 16'h9);                    // R10 hold
        cycle(1, 3'd6, 32'hAAAA_AAAA, 32'h1, 16'h1);            // R9
        cycle(1, 3'd7, 32'h1, 32'h2, 16'h8000);                 // R9
        cycle(1, 3'd3, 32'h0000_4000, 32'h0, 16'h0);            // R9 cleared by legal code
        cycle(0, 3'd0, 32'h0, 32'h0, 16'h0);                    // R10

        for (int i = 0; i < 400; i++) begin
            cycle(($urandom % 4) != 0, 3'($urandom), $urandom, $urandom, 16'($urandom));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule